// File: doc/BRIEF.md
# I2C Message Sequencer

This block runs one whole I2C message on its own. It acts as the bus master on the register port of a byte-level I2C controller, and that controller reports each bus event as an 8-bit status code. Every next step is chosen from the status code the controller returns. The steps are: issue START, send one or two address bytes, move the data bytes, then end with STOP.

The host starts a message with a one-cycle `start` pulse. With that pulse it gives:
- the device address;
- a 10-bit address flag;
- the direction;
- the byte count.

Bytes to transmit come in on a valid/ready stream. Received bytes leave on a second valid/ready stream.

When the message ends, the block pulses `done` and gives an error code:
- 0 = no error;
- 1 = no device answered;
- 2 = I/O error, meaning an unexpected status code.

An I/O error also soft-resets the controller. A read with a byte count of zero probes for a device.

The sequencer uses four controller registers, at parameter offsets:
- DATA, default 1;
- CONTROL, default 2;
- STATUS, default 3;
- RESET, default 7.

A register read returns its data on `bus_rdata` one cycle after `bus_rd`. The control register bits are:
- bit 2: ACK enable;
- bit 3: event flag;
- bit 4: STOP;
- bit 5: START;
- bit 6: controller enable.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset, `busy` and `done` are 0 and no register write is issued until `start`.
- R2: A `start` pulse in idle writes CONTROL = 0x64 (enable, ACK enable, START) and raises `busy`.
- R3: For a 7-bit address, on status 0x08 or 0x10 the DATA byte written is {addr[6:0], dir}, where dir = 1 means read. It is followed by a CONTROL write of 0x44.
- R4: For a 10-bit address, the first byte is 0xF0 | addr[9:8]<<1 | dir. On status 0x18 or 0x40 the second byte, addr[7:0], is written to DATA.
- R5: In a write, after status 0x18, 0xD0 or 0x28, the next stream byte is written to DATA followed by CONTROL 0x44. When no bytes remain, the block instead writes a CONTROL value with bits 6 and 4 set and finishes with error 0.
- R6: In a read, each CONTROL write carries ACK enable = 1 except the one written when exactly one byte is left to come; that one is 0x40. On status 0x50 the DATA byte is delivered on the rx stream. On 0x58 the byte is delivered, then CONTROL 0x50 (STOP) is written, and the block finishes with error 0.
- R7: A read with count 0 writes a STOP right after status 0x40 and delivers no byte.
- R8: Status 0x20, 0x30 or 0x48 leads to a STOP and error 1.
- R9: Any other status leads to a write of the RESET register, then a STOP, and error 2.
- R10: While idle, a set event flag is answered with exactly one CONTROL write with STOP set. There is no `done` and no other write.
- R11: If `abort` is raised during a write after at least one byte has been sent, the next ACK status leads to a STOP without sending further bytes.
- R12: STATUS is read only in the cycle right after a CONTROL read that returned the event flag set.
- R13: `rx_data` stays stable with `rx_valid` high until `rx_ready` is seen.
- R14: `done` is a single-cycle pulse, and `busy` is low while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a message (one-cycle pulse, idle only) |
| dev_addr | input | 10 | Device address |
| ten_bit | input | 1 | 10-bit address mode |
| rd | input | 1 | 1 = read, 0 = write |
| len | input | LEN_W | Byte count |
| abort | input | 1 | Request early end of the message |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | tx_data valid |
| tx_ready | output | 1 | tx_data taken |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data valid |
| rx_ready | input | 1 | rx_data taken |
| busy | output | 1 | Message in progress |
| done | output | 1 | Message finished (pulse) |
| err | output | 2 | Result: 0 none, 1 no device, 2 I/O |
| bus_addr | output | RA_W | Controller register offset |
| bus_wdata | output | 8 | Register write data |
| bus_wr | output | 1 | Register write strobe |
| bus_rd | output | 1 | Register read strobe |
| bus_rdata | input | 8 | Register read data, one cycle after bus_rd |

## Verification
The bench builds the block with its default parameters. `LEN_W` is 8, and the default register offsets are used, so the bench's controller model decodes the same offsets. These values bring both address modes within reach, along with zero-length probes and multi-byte reads in which the ACK-withdraw point moves with the count. The bench's model of the controller replays a status script for each message. This exercises unexpected codes, missing devices, an abort in the middle of a write and an event that arrives while idle, all against the exact sequence of register writes.

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq #(
  parameter int LEN_W    = 8,
  parameter int RA_W     = 3,
  parameter int DATA_OFS = 1,
  parameter int CTRL_OFS = 2,
  parameter int STAT_OFS = 3,
  parameter int SRST_OFS = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [9:0]       dev_addr,
  input  logic             ten_bit,
  input  logic             rd,
  input  logic [LEN_W-1:0] len,
  input  logic             abort,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             busy,
  output logic             done,
  output logic [1:0]       err,
  output logic [RA_W-1:0]  bus_addr,
  output logic [7:0]       bus_wdata,
  output logic             bus_wr,
  output logic             bus_rd,
  input  logic [7:0]       bus_rdata
);
  localparam logic [RA_W-1:0] A_DATA = RA_W'(DATA_OFS);
  localparam logic [RA_W-1:0] A_CTRL = RA_W'(CTRL_OFS);
  localparam logic [RA_W-1:0] A_STAT = RA_W'(STAT_OFS);
  localparam logic [RA_W-1:0] A_SRST = RA_W'(SRST_OFS);
  localparam logic [7:0] C_ACK = 8'h04, C_STP = 8'h10, C_STA = 8'h20, C_EN = 8'h40;
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  typedef enum logic [2:0] {M_IDLE, M_WSTART, M_WA1, M_WA2, M_WSACK, M_WSDATA} mst_t;
  typedef enum logic [2:0] {P_RD, P_CHK, P_DEC, P_TX, P_RXRD, P_RX, P_CTL} ph_t;

  mst_t mst, n_mst;
  ph_t  ph, n_ph;
  logic [LEN_W-1:0] left, n_left;
  logic moved, n_moved, abort_l, n_abort_l, ack_en, n_ack_en, ten_l, n_ten_l;
  logic fin, n_fin, rx_last, n_rx_last, n_done;
  logic [7:0] a1, n_a1, a2, n_a2, cval, n_cval, rxq, n_rxq;
  logic [1:0] err_n, n_err_n, n_err;

  wire idle   = (mst == M_IDLE);
  wire go     = start && idle && (ph == P_RD || ph == P_CHK);
  wire ab_eff = abort_l | abort;
  wire [7:0] base = C_EN | (ack_en ? C_ACK : 8'h00);

  assign busy     = !idle;
  assign rx_valid = (ph == P_RX);
  assign rx_data  = rxq;

  always_comb begin
    logic wack, rack, stp;
    n_mst = mst; n_ph = ph; n_left = left; n_moved = moved; n_abort_l = abort_l;
    n_ack_en = ack_en; n_ten_l = ten_l; n_fin = fin; n_rx_last = rx_last;
    n_a1 = a1; n_a2 = a2; n_cval = cval; n_rxq = rxq; n_err_n = err_n;
    n_err = err; n_done = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = A_CTRL; bus_wdata = 8'h00; tx_ready = 1'b0;
    wack = 1'b0; rack = 1'b0; stp = 1'b0;
    if (abort && !idle) n_abort_l = 1'b1;
    if (go) begin
      bus_wr = 1'b1; bus_wdata = C_EN | C_ACK | C_STA;
      n_mst = M_WSTART; n_ph = P_RD; n_left = len; n_moved = 1'b0; n_abort_l = 1'b0;
      n_ack_en = 1'b1; n_ten_l = ten_bit; n_fin = 1'b0; n_err_n = 2'd0;
      n_a1 = ten_bit ? (8'hF0 | {5'b0, dev_addr[9:8], 1'b0} | {7'b0, rd}) : {dev_addr[6:0], rd};
      n_a2 = dev_addr[7:0];
    end else begin
      case (ph)
        P_RD: begin bus_rd = 1'b1; n_ph = P_CHK; end
        P_CHK: begin
          if (bus_rdata[3]) begin
            if (idle) begin n_cval = base | C_STP; n_fin = 1'b0; n_ph = P_CTL; end
            else begin bus_rd = 1'b1; bus_addr = A_STAT; n_ph = P_DEC; end
          end else bus_rd = 1'b1;
        end
        P_DEC: begin
          case (bus_rdata)
            8'h08, 8'h10: begin
              bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = a1;
              n_cval = base; n_mst = M_WA1; n_ph = P_CTL;
            end
            8'h18, 8'h40: begin
              if (ten_l) begin
                bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = a2;
                n_cval = base; n_mst = M_WA2; n_ph = P_CTL;
              end else if (bus_rdata == 8'h18) wack = 1'b1;
              else rack = 1'b1;
            end
            8'hD0, 8'h28: wack = 1'b1;
            8'hE0: rack = 1'b1;
            8'h50, 8'h58: begin
              bus_rd = 1'b1; bus_addr = A_DATA; n_rx_last = (bus_rdata == 8'h58);
              n_mst = M_WSDATA; n_ph = P_RXRD;
            end
            8'h20, 8'h30, 8'h48: begin stp = 1'b1; n_err_n = 2'd1; end
            default: begin
              bus_wr = 1'b1; bus_addr = A_SRST; stp = 1'b1; n_err_n = 2'd2;
            end
          endcase
          if (wack) begin
            if (left == '0 || (ab_eff && moved)) stp = 1'b1;
            else begin n_ph = P_TX; n_mst = M_WSACK; end
          end
          if (rack) begin
            if (left == '0) stp = 1'b1;
            else begin
              n_mst = M_WSDATA;
              if (left == ONE || ab_eff) n_ack_en = 1'b0;
              n_cval = C_EN | (n_ack_en ? C_ACK : 8'h00); n_ph = P_CTL;
            end
          end
        end
        P_TX: if (tx_valid) begin
          bus_wr = 1'b1; bus_addr = A_DATA; bus_wdata = tx_data; tx_ready = 1'b1;
          n_left = left - ONE; n_moved = 1'b1; n_cval = base; n_ph = P_CTL;
        end
        P_RXRD: begin n_rxq = bus_rdata; n_ph = P_RX; end
        P_RX: if (rx_ready) begin
          if (rx_last) stp = 1'b1;
          else begin
            n_left = left - ONE;
            if (n_left == ONE || ab_eff) n_ack_en = 1'b0;
            n_cval = C_EN | (n_ack_en ? C_ACK : 8'h00); n_ph = P_CTL;
          end
        end
        P_CTL: begin
          bus_wr = 1'b1; bus_wdata = cval; n_ph = P_RD;
          if (fin) begin n_mst = M_IDLE; n_done = 1'b1; n_err = err_n; n_fin = 1'b0; end
        end
        default: n_ph = P_RD;
      endcase
      if (stp) begin n_cval = base | C_STP; n_fin = 1'b1; n_ph = P_CTL; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst <= M_IDLE; ph <= P_RD; left <= '0; moved <= 1'b0; abort_l <= 1'b0;
      ack_en <= 1'b1; ten_l <= 1'b0; fin <= 1'b0; rx_last <= 1'b0;
      a1 <= 8'h00; a2 <= 8'h00; cval <= 8'h00; rxq <= 8'h00;
      err_n <= 2'd0; err <= 2'd0; done <= 1'b0;
    end else begin
      mst <= n_mst; ph <= n_ph; left <= n_left; moved <= n_moved; abort_l <= n_abort_l;
      ack_en <= n_ack_en; ten_l <= n_ten_l; fin <= n_fin; rx_last <= n_rx_last;
      a1 <= n_a1; a2 <= n_a2; cval <= n_cval; rxq <= n_rxq;
      err_n <= n_err_n; err <= n_err; done <= n_done;
    end
  end

  logic prev_ctrl_rd;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_ctrl_rd <= 1'b0;
    else prev_ctrl_rd <= bus_rd && bus_addr == A_CTRL;

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n) !(bus_wr && bus_rd)); // R12
  AST_STAT_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_STAT) |-> (prev_ctrl_rd && bus_rdata[3])); // R12
  AST_CTRL_EN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL) |-> (bus_wdata[6] && !bus_wdata[3])); // R5
  AST_TX_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (tx_valid && bus_wr && bus_addr == A_DATA && bus_wdata == tx_data)); // R5
  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R14
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R14
  AST_IDLE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |-> !(bus_wr && bus_addr == A_DATA)); // R10
endmodule

// File: tb/tb_i2c_xfer_seq.sv
module tb_i2c_xfer_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ten_bit = 1'b0, rd = 1'b0, abort = 1'b0, rx_ready = 1'b0;
  logic [9:0] dev_addr = '0;
  logic [7:0] len = '0;
  logic [7:0] tx_data, rx_data, bus_wdata, bus_rdata;
  logic tx_valid, tx_ready, rx_valid, busy, done, bus_wr, bus_rd;
  logic [1:0] err;
  logic [2:0] bus_addr;

  always #2 clk = ~clk;

  i2c_xfer_seq dut (.clk, .rst_n, .start, .dev_addr, .ten_bit, .rd, .len, .abort,
    .tx_data, .tx_valid, .tx_ready, .rx_data, .rx_valid, .rx_ready, .busy, .done, .err,
    .bus_addr, .bus_wdata, .bus_wr, .bus_rd, .bus_rdata);

  int checks = 0, errors = 0;
  logic [7:0] script [16];
  int si = 0;
  logic [7:0] rxb [8];
  int rxi = 0;
  logic [7:0] txb [8];
  int txi = 0, txn = 0;
  logic [10:0] wlog [32];
  int wn = 0;
  logic [10:0] exp_l [32];
  int en = 0;
  logic [7:0] got [8];
  int gn = 0, dones = 0;
  logic flag = 1'b0, inj = 1'b0;
  logic [7:0] stat = 8'hF8;
  int pend = 0;
  int cyc = 0;

  assign tx_valid = (txi < txn);
  assign tx_data  = txb[txi & 7];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (done) dones <= dones + 1;
    if (rx_valid && rx_ready) begin got[gn & 7] <= rx_data; gn <= gn + 1; end
    if (tx_ready && tx_valid) txi <= txi + 1;
    if (bus_rd) begin
      if (bus_addr == 3'd2) bus_rdata <= {4'b0100, flag, 3'b000};
      else if (bus_addr == 3'd3) bus_rdata <= stat;
      else if (bus_addr == 3'd1) begin bus_rdata <= rxb[rxi & 7]; rxi <= rxi + 1; end
      else bus_rdata <= 8'h00;
    end
    if (inj) flag <= 1'b1;
    if (pend > 0) begin
      pend <= pend - 1;
      if (pend == 1) begin flag <= 1'b1; stat <= script[si & 15]; si <= si + 1; end
    end
    if (bus_wr) begin
      if (wn < 32) wlog[wn] <= {bus_addr, bus_wdata};
      wn <= wn + 1;
      if (bus_addr == 3'd2) begin
        flag <= 1'b0;
        if (!bus_wdata[4]) pend <= 4;
      end
    end
  end

  always @(negedge clk) rx_ready <= cyc[1];

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic ex(input logic [2:0] a, input logic [7:0] d);
    exp_l[en] = {a, d}; en++;
  endtask

  task automatic prep();
    en = 0; si = 0; rxi = 0; txi = 0; gn = 0;
    @(negedge clk); wn = 0; dones = 0;
  endtask

  task automatic run(input string req, input logic [9:0] a, input logic t, input logic r,
                     input logic [7:0] n, input logic [1:0] experr, input int nrx, input int abort_after);
    int k;
    @(negedge clk);
    dev_addr = a; ten_bit = t; rd = r; len = n; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({req, " busy"}, busy, 1);
    k = 0;
    while (!done && k < 3000) begin
      @(negedge clk); k++;
      if (abort_after >= 0 && txi > abort_after) abort = 1'b1;
    end
    abort = 1'b0;
    chk({req, " done"}, done, 1);
    chk({req, " err"}, err, experr);
    chk({req, " write count"}, wn, en);
    for (int i = 0; i < en && i < wn; i++) chk({req, " write entry"}, wlog[i], exp_l[i]);
    chk({req, " rx count"}, gn, nrx);
    for (int i = 0; i < nrx && i < gn; i++) chk({req, " rx byte"}, got[i], rxb[i]);
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 done after reset", done, 0);
    repeat (10) @(negedge clk);
    chk("R1 no write before start", wn, 0);
  endtask

  task automatic t_write7();
    prep();
    script[0] = 8'h08; script[1] = 8'h18; script[2] = 8'h28; script[3] = 8'h28;
    txb[0] = 8'hD0; txb[1] = 8'hD1; txn = 2;
    ex(2, 8'h64); ex(1, 8'hB4); ex(2, 8'h44); ex(1, 8'hD0); ex(2, 8'h44);
    ex(1, 8'hD1); ex(2, 8'h44); ex(2, 8'h54);
    run("R2 R3 R5 write7", 10'h05A, 1'b0, 1'b0, 8'd2, 2'd0, 0, -1);
    chk("R5 tx consumed", txi, 2);
  endtask

  task automatic t_write10();
    prep();
    script[0] = 8'h08; script[1] = 8'h18; script[2] = 8'hD0; script[3] = 8'h28;
    txb[0] = 8'h3C; txn = 1;
    ex(2, 8'h64); ex(1, 8'hF4); ex(2, 8'h44); ex(1, 8'hC5); ex(2, 8'h44);
    ex(1, 8'h3C); ex(2, 8'h44); ex(2, 8'h54);
    run("R4 write10", 10'h2C5, 1'b1, 1'b0, 8'd1, 2'd0, 0, -1);
  endtask

  task automatic t_read7();
    prep();
    script[0] = 8'h08; script[1] = 8'h40; script[2] = 8'h50; script[3] = 8'h50; script[4] = 8'h58;
    rxb[0] = 8'hA5; rxb[1] = 8'h5A; rxb[2] = 8'hC3; txn = 0;
    ex(2, 8'h64); ex(1, 8'h43); ex(2, 8'h44); ex(2, 8'h44); ex(2, 8'h44);
    ex(2, 8'h40); ex(2, 8'h50);
    run("R6 R13 read7", 10'h021, 1'b0, 1'b1, 8'd3, 2'd0, 3, -1);
  endtask

  task automatic t_read10();
    prep();
    script[0] = 8'h08; script[1] = 8'h40; script[2] = 8'hE0; script[3] = 8'h58;
    rxb[0] = 8'h99; txn = 0;
    ex(2, 8'h64); ex(1, 8'hF7); ex(2, 8'h44); ex(1, 8'hFF); ex(2, 8'h44);
    ex(2, 8'h40); ex(2, 8'h50);
    run("R4 R6 read10", 10'h3FF, 1'b1, 1'b1, 8'd1, 2'd0, 1, -1);
  endtask

  task automatic t_probe();
    prep();
    script[0] = 8'h10; script[1] = 8'h40; txn = 0;
    ex(2, 8'h64); ex(1, 8'hA1); ex(2, 8'h44); ex(2, 8'h54);
    run("R7 probe", 10'h050, 1'b0, 1'b1, 8'd0, 2'd0, 0, -1);
  endtask

  task automatic t_nodev();
    prep();
    script[0] = 8'h08; script[1] = 8'h20; txn = 0;
    ex(2, 8'h64); ex(1, 8'h22); ex(2, 8'h44); ex(2, 8'h54);
    run("R8 nodev", 10'h011, 1'b0, 1'b0, 8'd1, 2'd1, 0, -1);
  endtask

  task automatic t_ioerr();
    prep();
    script[0] = 8'h08; script[1] = 8'h99; txn = 0;
    ex(2, 8'h64); ex(1, 8'h22); ex(2, 8'h44); ex(7, 8'h00); ex(2, 8'h54);
    run("R9 ioerr", 10'h011, 1'b0, 1'b0, 8'd1, 2'd2, 0, -1);
  endtask

  task automatic t_abort();
    prep();
    script[0] = 8'h08; script[1] = 8'h18; script[2] = 8'h28; script[3] = 8'h28;
    txb[0] = 8'h11; txb[1] = 8'h22; txb[2] = 8'h33; txn = 3;
    ex(2, 8'h64); ex(1, 8'h0E); ex(2, 8'h44); ex(1, 8'h11); ex(2, 8'h44); ex(2, 8'h54);
    run("R11 abort", 10'h007, 1'b0, 1'b0, 8'd3, 2'd0, 0, 0);
    chk("R11 tx consumed", txi, 1);
  endtask

  task automatic t_idle_flag();
    prep();
    @(negedge clk); inj = 1'b1; @(negedge clk); inj = 1'b0;
    repeat (20) @(negedge clk);
    chk("R10 one write", wn, 1);
    chk("R10 stop write", wlog[0][10:8] == 3'd2 && wlog[0][4] && wlog[0][6], 1);
    chk("R10 no done", dones, 0);
    chk("R10 busy", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write7();
    t_write10();
    t_read7();
    t_read10();
    t_probe();
    t_nodev();
    t_ioerr();
    t_abort();
    t_idle_flag();
    chk("R14 done dropped", done, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule